// File: doc/BRIEF.md
# Partitioned Saturating Lane ALU

This block is a lane-parallel integer unit for a 64-bit data path. Each cycle it can accept two 64-bit operands, a lane-size code and an operation code. It treats the operands as eight bytes, four 16-bit words, two 32-bit dwords or one 64-bit qword, and it works on every lane at once. No carry or borrow passes from one lane into the next.

The operations are modular add and subtract, signed and unsigned clamping add and subtract, equality and signed greater-than tests that return whole-lane masks, unsigned and signed minimum and maximum, and a rounded unsigned average. Only some pairings of operation and lane size are legal. An illegal pairing returns zero and raises an error flag. The result is registered: it appears one clock after the request, together with a valid strobe.

Top module: `lane_alu`

## Requirements
- R1: Lane size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Operation 0 (modular add) and operation 1 (modular subtract, a minus b) are legal for every lane size. Each lane keeps only its low bits, and no carry or borrow crosses a lane boundary.
- R2: Operation 2 (signed clamping add) and operation 3 (signed clamping subtract) are legal only for 8-bit and 16-bit lanes. On overflow they return 0x7F or 0x80 for bytes, and 0x7FFF or 0x8000 for words.
- R3: Operation 4 (unsigned clamping add) and operation 5 (unsigned clamping subtract) are legal only for 8-bit and 16-bit lanes. On overflow the add returns all ones, and on underflow the subtract returns zero.
- R4: Operation 6 (equality test) is legal for 8-, 16- and 32-bit lanes. Each lane becomes all ones when a equals b and all zeros otherwise.
- R5: Operation 7 (signed greater-than test, a > b) is legal for 8-, 16- and 32-bit lanes. It produces the same whole-lane mask form as R4.
- R6: Operation 8 (unsigned minimum) and operation 9 (unsigned maximum) are legal only for 8-bit lanes.
- R7: Operation 10 (signed minimum) and operation 11 (signed maximum) are legal only for 16-bit lanes.
- R8: Operation 12 (unsigned average) is legal for 8-bit and 16-bit lanes. It returns (a + b + 1) >> 1 computed with one extra bit, so it never wraps.
- R9: Any other pairing is illegal, and so are operation codes 13 to 15 with any lane size. An illegal request sets `illegal` and returns a zero result.
- R10: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. After an idle cycle `illegal` is low and `result` keeps its previous value.
- R11: While reset is held, `out_valid` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| lane_sel | input | 2 | Lane size code |
| op_code | input | 4 | Operation code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Lane-wise result |
| illegal | output | 1 | Operation and lane size pairing not supported |

## Verification
The bench builds the unit with its default 64-bit data width. That width puts all four lane sizes in reach, including the single 64-bit lane whose carry-out must simply drop. Every one of the sixteen operation codes is crossed with every lane size over lane-replicated extremes: zero, all ones, the signed maximum, the signed minimum, one and a mixed pattern. This reaches each clamp point, each mask value and each illegal pairing. A random sweep with idle gaps follows. It exercises the result hold and the valid timing.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int NUM_SZ = 4;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } lane_sz_e;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDS  = 4'd2,
        OP_SUBS  = 4'd3,
        OP_ADDUS = 4'd4,
        OP_SUBUS = 4'd5,
        OP_EQ    = 4'd6,
        OP_GT    = 4'd7,
        OP_MINU  = 4'd8,
        OP_MAXU  = 4'd9,
        OP_MINS  = 4'd10,
        OP_MAXS  = 4'd11,
        OP_AVG   = 4'd12
    } alu_op_e;

endpackage

// File: rtl/lane_alu_decode.sv
module lane_alu_decode
    import lane_alu_pkg::*;
(
    input  logic [3:0] op,
    input  logic [1:0] sz,
    output logic       legal
);

    always_comb begin
        legal = 1'b0;
        case (op)
            OP_ADD, OP_SUB:                         legal = 1'b1;
            OP_ADDS, OP_SUBS, OP_ADDUS, OP_SUBUS:   legal = (sz == SZ_B8) || (sz == SZ_B16);
            OP_EQ, OP_GT:                           legal = (sz != SZ_B64);
            OP_MINU, OP_MAXU:                       legal = (sz == SZ_B8);
            OP_MINS, OP_MAXS:                       legal = (sz == SZ_B16);
            OP_AVG:                                 legal = (sz == SZ_B8) || (sz == SZ_B16);
            default:                                legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_alu_lane.sv
module lane_alu_lane
    import lane_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] ONES  = {W{1'b1}};
    localparam logic [W-1:0] ZERO  = {W{1'b0}};
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic [W:0] rnd_x;
    logic       ovf_add_s;
    logic       ovf_sub_s;
    logic       gt_s;
    logic       lt_u;

    always_comb begin
        sum_x     = {1'b0, a} + {1'b0, b};
        dif_x     = {1'b0, a} - {1'b0, b};
        rnd_x     = sum_x + {{W{1'b0}}, 1'b1};
        ovf_add_s = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        ovf_sub_s = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        gt_s      = $signed(a) > $signed(b);
        lt_u      = a < b;
    end

    always_comb begin
        case (op)
            OP_ADD:   y = sum_x[W-1:0];
            OP_SUB:   y = dif_x[W-1:0];
            OP_ADDS:  y = ovf_add_s ? (a[W-1] ? S_MIN : S_MAX) : sum_x[W-1:0];
            OP_SUBS:  y = ovf_sub_s ? (a[W-1] ? S_MIN : S_MAX) : dif_x[W-1:0];
            OP_ADDUS: y = sum_x[W] ? ONES : sum_x[W-1:0];
            OP_SUBUS: y = dif_x[W] ? ZERO : dif_x[W-1:0];
            OP_EQ:    y = (a == b) ? ONES : ZERO;
            OP_GT:    y = gt_s ? ONES : ZERO;
            OP_MINU:  y = lt_u ? a : b;
            OP_MAXU:  y = lt_u ? b : a;
            OP_MINS:  y = gt_s ? b : a;
            OP_MAXS:  y = gt_s ? a : b;
            OP_AVG:   y = rnd_x[W:1];
            default:  y = ZERO;
        endcase
    end

    always_comb begin
        // R4
        if (op == OP_EQ || op == OP_GT) begin
            cmp_mask_chk: assert (y == ZERO || y == ONES);
        end
        // R2
        if (op == OP_ADDS && a[W-1] != b[W-1]) begin
            mixed_sign_add_chk: assert (y == W'(a + b));
        end
        // R3
        if (op == OP_ADDUS) begin
            usat_add_floor_chk: assert (y >= a && y >= b);
        end
        // R3
        if (op == OP_SUBUS) begin
            usat_sub_ceil_chk: assert (y <= a);
        end
        // R8
        if (op == OP_AVG) begin
            avg_range_chk: assert ((y >= a || y >= b) && (y <= a || y <= b));
        end
    end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
    import lane_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        lane_sel,
    input  logic [3:0]        op_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] res;
    } st_t;

    st_t  st_d;
    st_t  st_q;
    logic legal;

    logic [NUM_SZ-1:0][DATA_W-1:0] part_res;

    lane_alu_decode i_decode (
        .op    (op_code),
        .sz    (lane_sel),
        .legal (legal)
    );

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
        localparam int LW = 8 << k;
        localparam int NL = DATA_W / LW;
        logic [DATA_W-1:0] sz_res;
        for (genvar j = 0; j < NL; j++) begin : g_lane
            lane_alu_lane #(.W(LW)) i_lane (
                .op (op_code),
                .a  (opnd_a[j*LW +: LW]),
                .b  (opnd_b[j*LW +: LW]),
                .y  (sz_res[j*LW +: LW])
            );
        end
        assign part_res[k] = sz_res;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.err = in_valid && !legal;
        if (in_valid) begin
            st_d.res = legal ? part_res[lane_sel] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign illegal   = st_q.err;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal && $stable(result)));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && result == '0));

    // R9
    qword_only_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == SZ_B64 && op_code != OP_ADD && op_code != OP_SUB) |=> illegal);

endmodule

// File: tb/test_lane_alu.sv
module test_lane_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [1:0]  lane_sel = '0;
    logic [3:0]  op_code = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [63:0] last_res = '0;

    typedef struct {
        logic        vld;
        logic        err;
        logic [63:0] res;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_alu i_lane_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .lane_sel  (lane_sel),
        .op_code   (op_code),
        .out_valid (out_valid),
        .result    (result),
        .illegal   (illegal)
    );

    function automatic bit ref_legal(int op, int ls);
        case (op)
            0, 1:          return 1'b1;
            2, 3, 4, 5:    return ls <= 1;
            6, 7:          return ls <= 2;
            8, 9:          return ls == 0;
            10, 11:        return ls == 1;
            12:            return ls <= 1;
            default:       return 1'b0;
        endcase
    endfunction

    function automatic string req_tag(int op, int ls);
        if (!ref_legal(op, ls)) return "R9";
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 5:    return "R3";
            6:       return "R4";
            7:       return "R5";
            8, 9:    return "R6";
            10, 11:  return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [63:0] ref_lane(int op, int w, logic [63:0] a, logic [63:0] b);
        logic [65:0]        pw, msk, ua, ub, u;
        logic signed [65:0] sa, sb, smax, smin, r;
        pw   = 66'd1 << w;
        msk  = pw - 66'd1;
        ua   = {2'b00, a} & msk;
        ub   = {2'b00, b} & msk;
        sa   = ua;
        sb   = ub;
        if (ua[w-1]) sa = ua - pw;
        if (ub[w-1]) sb = ub - pw;
        smax = (pw >> 1) - 66'd1;
        smin = 66'd0 - (pw >> 1);
        u = '0;
        case (op)
            0: u = ua + ub;
            1: u = ua - ub;
            2: begin r = sa + sb; if (r > smax) r = smax; if (r < smin) r = smin; u = r; end
            3: begin r = sa - sb; if (r > smax) r = smax; if (r < smin) r = smin; u = r; end
            4: begin u = ua + ub; if (u > msk) u = msk; end
            5: u = (ua < ub) ? 66'd0 : ua - ub;
            6: u = (ua == ub) ? msk : 66'd0;
            7: u = (sa > sb) ? msk : 66'd0;
            8: u = (ua < ub) ? ua : ub;
            9: u = (ua > ub) ? ua : ub;
            10: u = (sa < sb) ? ua : ub;
            11: u = (sa > sb) ? ua : ub;
            12: u = (ua + ub + 66'd1) >> 1;
            default: u = '0;
        endcase
        u = u & msk;
        return u[63:0];
    endfunction

    function automatic logic [63:0] ref_word(int op, int ls, logic [63:0] a, logic [63:0] b);
        int          w;
        logic [63:0] acc, m;
        w   = 8 << ls;
        m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        acc = '0;
        if (!ref_legal(op, ls)) return '0;
        for (int j = 0; j < 64 / w; j++) begin
            acc |= (ref_lane(op, w, (a >> (j*w)) & m, (b >> (j*w)) & m) & m) << (j*w);
        end
        return acc;
    endfunction

    function automatic logic [63:0] pattern(int kind, int ls);
        int          w;
        logic [63:0] lane_v, v;
        w = 8 << ls;
        case (kind)
            0: lane_v = 64'd0;
            1: lane_v = '1;
            2: lane_v = (64'd1 << (w-1)) - 64'd1;
            3: lane_v = 64'd1 << (w-1);
            4: lane_v = 64'd1;
            default: return 64'h8123_7F56_FF9A_00BC;
        endcase
        if (w != 64) lane_v &= (64'd1 << w) - 64'd1;
        v = '0;
        for (int j = 0; j < 64 / w; j++) v |= lane_v << (j*w);
        return v;
    endfunction

    task automatic send(int op, int ls, logic [63:0] a, logic [63:0] b);
        exp_t e;
        in_valid = 1'b1;
        op_code  = 4'(op);
        lane_sel = 2'(ls);
        opnd_a   = a;
        opnd_b   = b;
        e.vld    = 1'b1;
        e.err    = !ref_legal(op, ls);
        e.res    = ref_word(op, ls, a, b);
        e.tag    = req_tag(op, ls);
        last_res = e.res;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        exp_t e;
        in_valid = 1'b0;
        opnd_a   = 64'hDEAD_BEEF_0BAD_F00D;
        opnd_b   = 64'h1234_5678_9ABC_DEF0;
        op_code  = 4'd13;
        e.vld    = 1'b0;
        e.err    = 1'b0;
        e.res    = last_res;
        e.tag    = "R10";
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // scoreboard monitor: samples one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_valid == e.vld, (e.vld ? "R10" : e.tag), "out_valid",
                      64'(out_valid), 64'(e.vld));
                check(illegal == e.err, e.tag, "illegal", 64'(illegal), 64'(e.err));
                check(result == e.res, e.tag, "result", result, e.res);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
        check(illegal == 1'b0,   "R11", "illegal in reset",   64'(illegal),   64'd0);
        check(result == '0,      "R11", "result in reset",    result,         64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: carries stop at every lane boundary
        send(0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
        send(0, 1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
        send(1, 2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
        send(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002);
        // R2: signed clamp corners
        send(2, 0, pattern(2, 0), pattern(4, 0));
        send(3, 1, pattern(3, 1), pattern(4, 1));
        // R3: unsigned clamp corners
        send(4, 1, pattern(1, 1), pattern(4, 1));
        send(5, 0, pattern(0, 0), pattern(4, 0));
        // R8: average of extremes
        send(12, 0, pattern(1, 0), pattern(1, 0));
        // R9: illegal pairings
        send(2, 2, pattern(2, 2), pattern(4, 2));
        send(15, 0, pattern(1, 0), pattern(1, 0));
        idle();
        idle();

        // exhaustive corner sweep over all codes and sizes
        for (int op = 0; op < 16; op++) begin
            for (int ls = 0; ls < 4; ls++) begin
                for (int ka = 0; ka < 6; ka++) begin
                    for (int kb = 0; kb < 6; kb++) begin
                        send(op, ls, pattern(ka, ls), pattern(kb, ls));
                    end
                end
                idle();
            end
        end

        // random sweep with idle gaps
        for (int n = 0; n < 3000; n++) begin
            send(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 {$urandom, $urandom}, {$urandom, $urandom});
            if ((n % 7) == 3) idle();
        end

        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule